// File: doc/BRIEF.md
# MDIO Management Target with PHY Register File

This block is the management-side slave of a physical-layer device. It watches the management clock (MDC) and the bidirectional management data line (MDIO) as plain levels. Both are synchronised into the system clock domain, and MDC edges are found from the synchronised samples. A frame decoder walks through the preamble, the start pattern, the opcode, the PHY address, the register number, the turnaround and the data field.

Read frames are answered by driving the line with a data-out bit and an enable. Write frames update a 32-entry, 16-bit register file. Register 1 is not stored: it always reports a fixed status word that advertises capability, completed autonegotiation and link up. The target answers one configured PHY address. A read aimed at any other address returns all ones.

Top module: `mgmt_phy_target`

## Requirements
- R1: After reset `mdio_oe` and `mdio_o` are 0, the decoder waits for a preamble, and every stored register reads 0x0000.
- R2: A start is accepted only on a rising MDC that samples MDIO low, after at least 32 rising MDC edges since reset or since the end of the previous frame. A frame that follows a shorter preamble is ignored.
- R3: On rising MDC edges, after the start bits 0 then 1, the target shifts in these fields, each MSB first: a 2-bit opcode, a 5-bit PHY address, a 5-bit register number, then 2 turnaround bits and 16 data bits.
- R4: A read frame (opcode 10) to PHY address 1 returns the addressed register MSB first. Each bit is valid before the rising MDC on which the host samples it.
- R5: Register 1 always reads 0x782C. A write to register 1 has no effect.
- R6: A write frame (opcode 01) to PHY address 1 stores all 16 data bits, including the last one. The store happens only on the rising MDC of the 16th data bit.
- R7: A read frame to any PHY address other than 1 returns 0xFFFF, with the line driven.
- R8: A write to another PHY address changes no register. So does a frame with opcode 00 or 11. During such frames `mdio_oe` stays 0.
- R9: `mdio_oe` rises at the end of the turnaround of a read frame and falls on the 16th rising MDC of the data field. At all other times it is 0.
- R10: `mdio_o` changes only after a falling MDC, or when a read is loaded at the end of the turnaround.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples MDC and MDIO |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock level |
| mdio_i | input | 1 | Management data level seen on the line |
| mdio_o | output | 1 | Value the target drives during a read |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |

## Verification
The write commit and the shift of the final data bit fall in the same system-clock cycle. The stored word must therefore merge the bit sampled on that very edge. The bench provokes this with write words whose last bit alone differs, such as 0x0001, and judges the result by reading the register back in a later frame. Turnaround-end loading and the output-enable change also share one MDC edge; the bench checks that the enable is low through every header bit and high across all 16 read-data samples.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [2:0] {
    ST_PRE,
    ST_SOF,
    ST_OPC,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DAT
  } mf_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mgmt_sync_edge.sv
module mgmt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_bit
);
  logic [STAGES-1:0] mdc_sh_q;
  logic [STAGES-1:0] dio_sh_q;
  logic              mdc_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_sh_q <= '0;
          dio_sh_q <= '0;
        end else begin
          mdc_sh_q <= mdc_i;
          dio_sh_q <= mdio_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_sh_q <= '0;
          dio_sh_q <= '0;
        end else begin
          mdc_sh_q <= {mdc_sh_q[STAGES-2:0], mdc_i};
          dio_sh_q <= {dio_sh_q[STAGES-2:0], mdio_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_prev_q <= 1'b0;
    else        mdc_prev_q <= mdc_sh_q[STAGES-1];
  end

  assign mdc_rise = mdc_sh_q[STAGES-1] & ~mdc_prev_q;
  assign mdc_fall = ~mdc_sh_q[STAGES-1] & mdc_prev_q;
  assign mdio_bit = dio_sh_q[STAGES-1];

  a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mdc_rise, mdc_fall}));
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs #(
  parameter int          DW          = 16,
  parameter int          NREG        = 32,
  parameter int          STATUS_IDX  = 1,
  parameter logic [15:0] STATUS_WORD = 16'h782C,
  localparam int         AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] words [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_word
      if (i == STATUS_IDX) begin : g_const
        assign words[i] = DW'(STATUS_WORD);
      end else begin : g_store
        logic [DW-1:0] q;
        logic          en;
        assign en = wr_en && (wr_idx == AW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q <= '0;
          else if (en) q <= wr_data;
        end
        assign words[i] = q;
      end
    end
  endgenerate

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mgmt_frame_dec.sv
module mgmt_frame_dec
  import mgmt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 5,
  parameter int PRE_MIN  = 32,
  parameter int PHY_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc_rise,
  input  logic          mdc_fall,
  input  logic          mdio_bit,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_idx,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int CNT_MAX = (PRE_MIN > DW) ? PRE_MIN : DW;
  localparam int CW      = $clog2(CNT_MAX + 1);

  mf_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    op_q, op_d;
  logic [AW-1:0] phy_q, phy_d;
  logic [AW-1:0] reg_q, reg_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          out_q, out_d;
  logic          oe_q, oe_d;
  logic          hit;
  logic [DW-1:0] rd_word;

  assign hit     = (phy_q == AW'(PHY_ADDR));
  assign rd_word = hit ? rd_data : '1;
  assign rd_idx  = reg_q;
  assign wr_idx  = reg_q;
  assign wr_data = {sh_q[DW-2:0], mdio_bit};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    sh_d    = sh_q;
    out_d   = out_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    unique case (state_q)
      ST_PRE: if (mdc_rise) begin
        if (cnt_q >= CW'(PRE_MIN) && !mdio_bit) begin
          state_d = ST_SOF;
          cnt_d   = '0;
        end else if (cnt_q < CW'(CNT_MAX)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SOF: if (mdc_rise) begin
        state_d = ST_OPC;
        cnt_d   = '0;
      end
      ST_OPC: if (mdc_rise) begin
        op_d  = {op_q[0], mdio_bit};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d = ST_PHY;
          cnt_d   = '0;
        end
      end
      ST_PHY: if (mdc_rise) begin
        phy_d = {phy_q[AW-2:0], mdio_bit};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(AW - 1)) begin
          state_d = ST_REG;
          cnt_d   = '0;
        end
      end
      ST_REG: if (mdc_rise) begin
        reg_d = {reg_q[AW-2:0], mdio_bit};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(AW - 1)) begin
          state_d = ST_TA;
          cnt_d   = '0;
        end
      end
      ST_TA: if (mdc_rise) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d = ST_DAT;
          cnt_d   = '0;
          if (op_q == OP_RD) begin
            oe_d  = 1'b1;
            sh_d  = rd_word;
            out_d = rd_word[DW-1];
          end
        end
      end
      ST_DAT: begin
        if (mdc_fall && oe_q) begin
          out_d = sh_q[DW-1];
          sh_d  = {sh_q[DW-2:0], 1'b0};
        end
        if (mdc_rise) begin
          if (!oe_q) sh_d = wr_data;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) begin
            state_d = ST_PRE;
            cnt_d   = '0;
            oe_d    = 1'b0;
            wr_en   = (op_q == OP_WR) && hit;
          end
        end
      end
      default: state_d = ST_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PRE;
      cnt_q   <= '0;
      op_q    <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;

  a_r9_oe_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_rise |=> $stable(oe_q));
  a_r9_oe_starts_after_ta: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(state_q) == ST_TA);
  a_r10_out_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc_rise && !mdc_fall) |=> $stable(out_q));
  a_r8_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> op_q == OP_RD);
endmodule

// File: rtl/mgmt_phy_target.sv
module mgmt_phy_target #(
  parameter int          PHY_ADDR    = 1,
  parameter int          NREG        = 32,
  parameter int          DW          = 16,
  parameter int          PRE_MIN     = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] STATUS_WORD = 16'h782C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdio_o,
  output logic mdio_oe
);
  localparam int AW = $clog2(NREG);

  logic          mdc_rise, mdc_fall, mdio_bit;
  logic          wr_en;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] wr_data, rd_data;

  mgmt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_i    (mdc_i),
    .mdio_i   (mdio_i),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_bit (mdio_bit)
  );

  mgmt_frame_dec #(
    .DW(DW), .AW(AW), .PRE_MIN(PRE_MIN), .PHY_ADDR(PHY_ADDR)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_bit (mdio_bit),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mgmt_phy_regs #(
    .DW(DW), .NREG(NREG), .STATUS_IDX(1), .STATUS_WORD(STATUS_WORD)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  a_r6_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mdc_rise);
  a_r9_no_drive_during_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mdio_oe);
endmodule

// File: tb/mgmt_phy_target_test.sv
module mgmt_phy_target_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc_i = 1'b0;
  logic mdio_i = 1'b1;
  logic mdio_o, mdio_oe;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  mgmt_phy_target uut (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One MDC period: low half then high half; output sampled late in the low half.
  task automatic mdc_cycle(input logic b, output logic seen, output logic seen_oe);
    mdio_i = b;
    mdc_i  = 1'b0;
    repeat (8) @(negedge clk);
    seen    = mdio_o;
    seen_oe = mdio_oe;
    mdc_i   = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd,
                       output logic [15:0] rd, output int oe_data, output int oe_hdr);
    logic s, e;
    logic [13:0] hdr;
    rd = '0; oe_data = 0; oe_hdr = 0;
    for (int i = 0; i < pre; i++) begin
      mdc_cycle(1'b1, s, e);
      if (e) oe_hdr++;
    end
    hdr = {2'b01, op, phy, rg};
    for (int i = 13; i >= 0; i--) begin
      mdc_cycle(hdr[i], s, e);
      if (e) oe_hdr++;
    end
    for (int i = 0; i < 2; i++) begin
      mdc_cycle(i == 0, s, e);
      if (e) oe_hdr++;
    end
    for (int i = 15; i >= 0; i--) begin
      mdc_cycle((op == 2'b10) ? 1'b1 : wd[i], s, e);
      rd = {rd[14:0], s};
      if (e) oe_data++;
    end
    mdio_i = 1'b1;
    mdc_i  = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                          input string tag);
    logic [15:0] rd; int od, oh;
    frame(32, 2'b01, phy, rg, wd, rd, od, oh);
    check({tag, " no drive in write"}, od + oh, 0);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp,
                         input string tag);
    logic [15:0] rd; int od, oh;
    frame(32, 2'b10, phy, rg, 16'h0, rd, od, oh);
    check({tag, " read value"}, rd, exp);
    check("R9 oe high over data", od, 16);
    check("R9 oe low in header", oh, 0);
    check("R9 oe low after frame", mdio_oe, 0);
  endtask

  task automatic t_reset;
    check("R1 oe after reset", mdio_oe, 0);
    check("R1 mdio_o after reset", mdio_o, 0);
    do_read(5'd1, 5'd3, 16'h0000, "R1 stored reg reset");
  endtask

  task automatic t_write_read;
    do_write(5'd1, 5'd0, 16'h1234, "R6");
    do_read(5'd1, 5'd0, 16'h1234, "R4 R3");
    do_write(5'd1, 5'd31, 16'hBEEF, "R6");
    do_read(5'd1, 5'd31, 16'hBEEF, "R4 top register");
    do_read(5'd1, 5'd0, 16'h1234, "R4 neighbour intact");
  endtask

  task automatic t_last_bit;
    do_write(5'd1, 5'd2, 16'h0001, "R6");
    do_read(5'd1, 5'd2, 16'h0001, "R6 last bit stored");
    do_write(5'd1, 5'd2, 16'h8000, "R6");
    do_read(5'd1, 5'd2, 16'h8000, "R6 first bit stored");
  endtask

  task automatic t_status;
    do_read(5'd1, 5'd1, 16'h782C, "R5 status word");
    do_write(5'd1, 5'd1, 16'h0000, "R5");
    do_read(5'd1, 5'd1, 16'h782C, "R5 write ignored");
  endtask

  task automatic t_other_addr;
    do_read(5'd5, 5'd0, 16'hFFFF, "R7 absent phy");
    do_write(5'd5, 5'd0, 16'h0000, "R8");
    do_read(5'd1, 5'd0, 16'h1234, "R8 foreign write ignored");
  endtask

  task automatic t_bad_opcode;
    logic [15:0] rd; int od, oh;
    frame(32, 2'b11, 5'd1, 5'd0, 16'h0000, rd, od, oh);
    check("R8 opcode 11 no drive", od + oh, 0);
    frame(32, 2'b00, 5'd1, 5'd0, 16'h0000, rd, od, oh);
    check("R8 opcode 00 no drive", od + oh, 0);
    do_read(5'd1, 5'd0, 16'h1234, "R8 opcode frames ignored");
  endtask

  task automatic t_short_preamble;
    logic [15:0] rd; int od, oh;
    frame(8, 2'b01, 5'd1, 5'd0, 16'hA5FF, rd, od, oh);
    check("R2 short frame no drive", od + oh, 0);
    do_read(5'd1, 5'd0, 16'h1234, "R2 short preamble ignored");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_last_bit();
    t_status();
    t_other_addr();
    t_bad_opcode();
    t_short_preamble();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule